// File: doc/BRIEF.md
# LDT Register Load Unit

This block performs the checked update of the local descriptor table register (LDTR). A single-cycle start pulse presents a source operand, the current privilege level, a protected-mode flag and the base and limit of the global descriptor table. The unit screens the request and, when a table entry is needed, fetches the 8-byte descriptor through a request/valid read port. On success it loads the LDTR selector, base, limit and valid bit. On failure it leaves the LDTR alone and reports a fault class together with an error code.

Every accepted start produces exactly one done pulse, and that pulse carries either success or one fault. The unit does not decode the instruction, handle the fault, translate addresses, or check the segment of a memory operand. Only one operation is in flight at a time, and a start that arrives while a read is outstanding is dropped.

Fault classes on `fault_o`: 0 = none, 1 = invalid operation, 2 = general protection, 3 = segment not present.

Top module: `ldtr_load_unit`

## Requirements
- R1: When `prot_mode_i` is 0, a start ends with fault class 1 and error code 0. The LDTR does not change and no memory read is issued. This check outranks every other check.
- R2: In protected mode with `cpl_i` not 0, a start ends with fault class 2 and error code 0. The LDTR does not change and no memory read is issued.
- R3: A selector whose bits 15:2 are all zero counts as null. It completes with fault class 0 and no memory read. The selector is loaded as given, base and limit are cleared to 0, and the valid bit is cleared.
- R4: A non-null selector with bit 2 (table indicator) set ends with fault class 2, the error code is the 16-bit selector, and no memory read is issued.
- R5: The byte offset is the selector with bits 2:0 cleared. If offset + 7 exceeds `gdt_limit_i`, the start ends with fault class 2, the error code is the selector, and no read is issued. offset + 7 equal to the limit passes.
- R6: The read address is `gdt_base_i` + offset. `mem_req_o` stays high with a stable address until a cycle in which `mem_valid_i` is high.
- R7: If the fetched descriptor has type bits 43:40 not equal to 4'b0010, or has bit 44 set, the operation ends with fault class 2 and the selector as error code. This check outranks R8.
- R8: If the descriptor passes R7 but its present bit 47 is 0, the operation ends with fault class 3 and the selector as error code.
- R9: On success the LDTR takes the selector, base = {d[63:56], d[39:16]}, limit = {d[51:48], d[15:0]}, and valid = 1. The done pulse shows fault class 0 and error code 0.
- R10: Only bits 15:0 of `selector_i` are used. Higher bits have no effect on any output.
- R11: Each accepted start produces exactly one one-cycle done pulse. A start while a read is outstanding is ignored. A rejected start raises done in the cycle after the start. A fetch raises done in the cycle after the valid cycle.
- R12: After reset the LDTR reads selector 0, base 0, limit 0, invalid, with no request and no done.
- R13: While done is low, the fault class and error code are 0. The LDTR outputs change only with a done pulse that reports fault class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| selector_i | input | SRC_W | Source operand; low 16 bits are the selector |
| cpl_i | input | 2 | Current privilege level |
| prot_mode_i | input | 1 | Protected mode active |
| gdt_base_i | input | ADDR_W | Global table base address |
| gdt_limit_i | input | GLIM_W | Global table limit in bytes |
| mem_req_o | output | 1 | Descriptor read request, held until valid |
| mem_addr_o | output | ADDR_W | Descriptor byte address |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Descriptor data |
| done_o | output | 1 | Operation complete, one cycle |
| fault_o | output | 2 | Fault class (0 none, 1 invalid op, 2 GP, 3 not present) |
| err_code_o | output | 16 | Error code, valid with done |
| ldtr_sel_o | output | 16 | LDTR selector |
| ldtr_base_o | output | 32 | LDTR base |
| ldtr_limit_o | output | 20 | LDTR limit |
| ldtr_valid_o | output | 1 | LDTR holds a usable table |

## Verification
The bench targets the ordering of the checks. It combines real mode with a nonzero privilege level, a wrong type with a cleared present bit, and a null selector carrying nonzero request-level bits. A design that ranked these wrongly would report the wrong fault class or error code. It also probes the limit boundary, where offset + 7 equals the limit and where it exceeds it by one. An off-by-one adder there would either reject the last legal entry or read past the table. The bench puts garbage in the high operand bits, which a design that leaked them would turn into a changed address or error code. It also pulses start while a read is outstanding, which a design that failed to block it would answer with a second done pulse or a clobbered selector.

// File: rtl/ldtr_pkg.sv
package ldtr_pkg;
  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;
  localparam int BASE_W = 32;
  localparam int LIM_W  = 20;
  localparam logic [3:0] LDT_TYPE = 4'b0010;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2,
    FLT_NP   = 2'd3
  } fault_e;
endpackage

// File: rtl/ldtr_precheck.sv
module ldtr_precheck
  import ldtr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GLIM_W = 16
) (
  input  logic              prot_mode_i,
  input  logic [1:0]        cpl_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [GLIM_W-1:0] gdt_limit_i,
  output fault_e            fault_o,
  output logic [SEL_W-1:0]  err_o,
  output logic              null_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int CMP_W = ((GLIM_W > SEL_W) ? GLIM_W : SEL_W) + 1;

  logic [SEL_W-1:0] offset;
  logic [CMP_W-1:0] last_byte;
  logic             over_limit;

  assign offset     = {sel_i[SEL_W-1:3], 3'b000};
  assign last_byte  = CMP_W'(offset) + CMP_W'(7);
  assign over_limit = last_byte > CMP_W'(gdt_limit_i);
  assign null_o     = (sel_i[SEL_W-1:2] == '0);
  assign addr_o     = gdt_base_i + ADDR_W'(offset);

  // priority: mode, privilege, null, table bit / limit
  always_comb begin
    fault_o = FLT_NONE;
    err_o   = '0;
    if (!prot_mode_i) begin
      fault_o = FLT_UD;
    end else if (cpl_i != 2'd0) begin
      fault_o = FLT_GP;
    end else if (null_o) begin
      fault_o = FLT_NONE;
    end else if (sel_i[2] || over_limit) begin
      fault_o = FLT_GP;
      err_o   = sel_i;
    end
  end
endmodule

// File: rtl/ldtr_desc_decode.sv
module ldtr_desc_decode
  import ldtr_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  output logic [BASE_W-1:0] base_o,
  output logic [LIM_W-1:0]  limit_o,
  output fault_e            fault_o
);
  logic type_bad;
  logic present;
  logic unused_desc;

  assign base_o      = {desc_i[63:56], desc_i[39:16]};
  assign limit_o     = {desc_i[51:48], desc_i[15:0]};
  assign type_bad    = (desc_i[43:40] != LDT_TYPE) || desc_i[44];
  assign present     = desc_i[47];
  assign unused_desc = ^{desc_i[55:52], desc_i[46:45]};

  always_comb begin
    if (type_bad)      fault_o = FLT_GP;
    else if (!present) fault_o = FLT_NP;
    else               fault_o = FLT_NONE;
  end
endmodule

// File: rtl/ldtr_state_reg.sv
module ldtr_state_reg
  import ldtr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic              valid_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [BASE_W-1:0] base_o,
  output logic [LIM_W-1:0]  limit_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= '0;
      base_o  <= '0;
      limit_o <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      sel_o   <= sel_i;
      base_o  <= base_i;
      limit_o <= limit_i;
      valid_o <= valid_i;
    end
  end
endmodule

// File: rtl/ldtr_load_unit.sv
module ldtr_load_unit
  import ldtr_pkg::*;
#(
  parameter int SRC_W  = 32,
  parameter int ADDR_W = 32,
  parameter int GLIM_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SRC_W-1:0]  selector_i,
  input  logic [1:0]        cpl_i,
  input  logic              prot_mode_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [GLIM_W-1:0] gdt_limit_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DESC_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [1:0]        fault_o,
  output logic [SEL_W-1:0]  err_code_o,
  output logic [SEL_W-1:0]  ldtr_sel_o,
  output logic [BASE_W-1:0] ldtr_base_o,
  output logic [LIM_W-1:0]  ldtr_limit_o,
  output logic              ldtr_valid_o
);
  typedef enum logic {ST_IDLE, ST_FETCH} state_e;

  state_e            state_q;
  logic [SEL_W-1:0]  sel_in, sel_q, err_q;
  logic [ADDR_W-1:0] addr_q, pre_addr;
  logic              done_q, pre_null;
  fault_e            fault_q, pre_fault, dec_fault;
  logic [SEL_W-1:0]  pre_err;
  logic [BASE_W-1:0] dec_base, ld_base;
  logic [LIM_W-1:0]  dec_limit, ld_limit;
  logic [SEL_W-1:0]  ld_sel;
  logic              ld_en, ld_valid;
  logic              accept, unused_src;

  // operand size has no effect: upper source bits dropped
  assign sel_in     = selector_i[SEL_W-1:0];
  assign unused_src = ^selector_i;
  assign accept     = (state_q == ST_IDLE) && start_i;

  ldtr_precheck #(.ADDR_W(ADDR_W), .GLIM_W(GLIM_W)) u_pre (
    .prot_mode_i (prot_mode_i),
    .cpl_i       (cpl_i),
    .sel_i       (sel_in),
    .gdt_base_i  (gdt_base_i),
    .gdt_limit_i (gdt_limit_i),
    .fault_o     (pre_fault),
    .err_o       (pre_err),
    .null_o      (pre_null),
    .addr_o      (pre_addr)
  );

  ldtr_desc_decode u_dec (
    .desc_i  (mem_rdata_i),
    .base_o  (dec_base),
    .limit_o (dec_limit),
    .fault_o (dec_fault)
  );

  always_comb begin
    ld_en    = 1'b0;
    ld_sel   = sel_q;
    ld_base  = dec_base;
    ld_limit = dec_limit;
    ld_valid = 1'b1;
    if (accept && pre_fault == FLT_NONE && pre_null) begin
      ld_en    = 1'b1;
      ld_sel   = sel_in;
      ld_base  = '0;
      ld_limit = '0;
      ld_valid = 1'b0;
    end else if (state_q == ST_FETCH && mem_valid_i && dec_fault == FLT_NONE) begin
      ld_en = 1'b1;
    end
  end

  ldtr_state_reg u_ldtr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ld_en),
    .sel_i   (ld_sel),
    .base_i  (ld_base),
    .limit_i (ld_limit),
    .valid_i (ld_valid),
    .sel_o   (ldtr_sel_o),
    .base_o  (ldtr_base_o),
    .limit_o (ldtr_limit_o),
    .valid_o (ldtr_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      err_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      err_q   <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (pre_fault != FLT_NONE || pre_null) begin
              done_q  <= 1'b1;
              fault_q <= pre_fault;
              err_q   <= pre_err;
            end else begin
              state_q <= ST_FETCH;
              sel_q   <= sel_in;
              addr_q  <= pre_addr;
            end
          end
        end
        ST_FETCH: begin
          if (mem_valid_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            fault_q <= dec_fault;
            err_q   <= (dec_fault != FLT_NONE) ? sel_q : '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = addr_q;
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign err_code_o = err_q;
endmodule

// File: rtl/ldtr_load_chk.sv
module ldtr_load_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i,
  input logic              done_o,
  input logic [1:0]        fault_o,
  input logic [15:0]       err_code_o,
  input logic [15:0]       ldtr_sel_o,
  input logic [31:0]       ldtr_base_o,
  input logic [19:0]       ldtr_limit_o,
  input logic              ldtr_valid_o
);
  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

  // R11
  resp_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i |=> done_o && !mem_req_o);

  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && start_i && !mem_valid_i |=> mem_req_o && !done_o);

  // R11
  req_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o);

  // R13
  quiet_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> fault_o == 2'd0 && err_code_o == 16'd0);

  // R13
  ldtr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o == 2'd0) |-> $stable(ldtr_sel_o) && $stable(ldtr_base_o)
      && $stable(ldtr_limit_o) && $stable(ldtr_valid_o));

  // R1
  ud_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o == 2'd1 |-> err_code_o == 16'd0);

  // R9
  ok_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o == 2'd0 |-> ldtr_valid_o == (ldtr_sel_o[15:2] != 14'd0));
endmodule

bind ldtr_load_unit ldtr_load_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_ldtr_load_unit.sv
`timescale 1ns/1ps
module tb_ldtr_load_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] selector_i = '0;
  logic [1:0]  cpl_i = '0;
  logic        prot_mode_i = 1'b0;
  logic [31:0] gdt_base_i = '0;
  logic [15:0] gdt_limit_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        done_o;
  logic [1:0]  fault_o;
  logic [15:0] err_code_o, ldtr_sel_o;
  logic [31:0] ldtr_base_o;
  logic [19:0] ldtr_limit_o;
  logic        ldtr_valid_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [1:0]  e_fault;
  logic [15:0] e_err;
  logic        e_req;
  logic [31:0] e_addr;
  logic [15:0] sh_sel = '0;
  logic [31:0] sh_base = '0;
  logic [19:0] sh_lim = '0;
  logic        sh_val = 1'b0;

  always #2 clk = ~clk;

  ldtr_load_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .selector_i(selector_i),
    .cpl_i(cpl_i), .prot_mode_i(prot_mode_i), .gdt_base_i(gdt_base_i),
    .gdt_limit_i(gdt_limit_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i), .done_o(done_o),
    .fault_o(fault_o), .err_code_o(err_code_o), .ldtr_sel_o(ldtr_sel_o),
    .ldtr_base_o(ldtr_base_o), .ldtr_limit_o(ldtr_limit_o), .ldtr_valid_o(ldtr_valid_o)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model from the requirements; updates the shadow LDTR on success
  task automatic model(input logic [31:0] src, input logic [1:0] cpl, input logic pm,
                       input logic [31:0] gbase, input logic [15:0] glim, input logic [63:0] d);
    logic [15:0] s;
    logic [16:0] last;
    s    = src[15:0];
    last = {1'b0, s[15:3], 3'b000} + 17'd7;
    e_req = 1'b0; e_fault = 2'd0; e_err = 16'd0;
    e_addr = gbase + {16'd0, s[15:3], 3'b000};
    if (!pm) e_fault = 2'd1;
    else if (cpl != 2'd0) e_fault = 2'd2;
    else if (s[15:2] == 14'd0) begin
      sh_sel = s; sh_base = '0; sh_lim = '0; sh_val = 1'b0;
    end else if (s[2] || last > {1'b0, glim}) begin
      e_fault = 2'd2; e_err = s;
    end else begin
      e_req = 1'b1;
      if (d[43:40] != 4'b0010 || d[44]) begin e_fault = 2'd2; e_err = s; end
      else if (!d[47]) begin e_fault = 2'd3; e_err = s; end
      else begin
        sh_sel = s; sh_base = {d[63:56], d[39:16]}; sh_lim = {d[51:48], d[15:0]}; sh_val = 1'b1;
      end
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] src, input logic [1:0] cpl,
                        input logic pm, input logic [31:0] gbase, input logic [15:0] glim,
                        input logic [63:0] d, input int lat, input bit poke);
    logic [15:0] o_sel;
    logic [31:0] o_base;
    logic [19:0] o_lim;
    logic        o_val, req_seen, got_done;
    int          waited;
    o_sel = sh_sel; o_base = sh_base; o_lim = sh_lim; o_val = sh_val;
    model(src, cpl, pm, gbase, glim, d);
    req_seen = 1'b0; got_done = 1'b0; waited = 0;
    @(negedge clk);
    selector_i = src; cpl_i = cpl; prot_mode_i = pm;
    gdt_base_i = gbase; gdt_limit_i = glim; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      start_i = 1'b0;
      mem_valid_i = 1'b0;
      if (done_o) begin got_done = 1'b1; break; end
      if (ldtr_sel_o !== o_sel || ldtr_base_o !== o_base || ldtr_limit_o !== o_lim || ldtr_valid_o !== o_val)
        chk("R13", "ldtr before done", {ldtr_sel_o, ldtr_base_o}, {o_sel, o_base});
      if (mem_req_o) begin
        if (!req_seen) begin
          req_seen = 1'b1;
          chk("R6", "read address", mem_addr_o, e_addr);
          if (poke) begin
            start_i = 1'b1; selector_i = 32'h0; prot_mode_i = 1'b0;
          end
        end
        if (waited >= lat) begin
          mem_valid_i = 1'b1; mem_rdata_i = d;
        end
        waited++;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    mem_valid_i = 1'b0;
    chk("R11", "done seen", got_done, 1'b1);
    if (!got_done) return;
    chk(req, "read issued", req_seen, e_req);
    chk(req, "fault class", fault_o, e_fault);
    chk(req, "error code", err_code_o, e_err);
    chk(req, "ldtr", {ldtr_sel_o, ldtr_base_o, ldtr_limit_o, ldtr_valid_o},
        {sh_sel, sh_base, sh_lim, sh_val});
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R11", "single done", done_o, 1'b0);
    end
  endtask

  function automatic logic [63:0] good_desc(input logic [31:0] b, input logic [19:0] l);
    good_desc = {b[31:24], 4'h0, l[19:16], 1'b1, 2'b00, 1'b0, 4'b0010, b[23:0], l[15:0]};
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [31:0] s;
    logic [15:0] gl;
    void'($urandom(32'h1d7_5eed));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "reset ldtr", {ldtr_sel_o, ldtr_base_o, ldtr_limit_o, ldtr_valid_o}, 69'd0);
    chk("R12", "reset req/done", {mem_req_o, done_o}, 2'b00);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R12", "idle after reset", {mem_req_o, done_o, fault_o}, 4'd0);

    d = good_desc(32'hA1B2_C3D4, 20'h5_6789);
    run_op("R9",  32'h0000_0010, 2'd0, 1'b1, 32'h0010_0000, 16'hFFFF, d, 2, 0);
    run_op("R1",  32'h0000_0018, 2'd3, 1'b0, 32'h0010_0000, 16'hFFFF, d, 0, 0);
    run_op("R2",  32'h0000_0018, 2'd1, 1'b1, 32'h0010_0000, 16'hFFFF, d, 0, 0);
    run_op("R3",  32'h0000_0003, 2'd0, 1'b1, 32'h0010_0000, 16'hFFFF, d, 0, 0);
    run_op("R9",  32'h0000_0020, 2'd0, 1'b1, 32'h0010_0000, 16'hFFFF, d, 0, 0);
    run_op("R3",  32'h0000_0000, 2'd0, 1'b1, 32'h0010_0000, 16'h0000, d, 0, 0);
    run_op("R4",  32'h0000_000C, 2'd0, 1'b1, 32'h0010_0000, 16'hFFFF, d, 0, 0);
    run_op("R5",  32'h0000_0008, 2'd0, 1'b1, 32'h0000_4000, 16'h000F, d, 1, 0);
    run_op("R5",  32'h0000_000B, 2'd0, 1'b1, 32'h0000_4000, 16'h000E, d, 1, 0);
    run_op("R5",  32'h0000_FFF8, 2'd0, 1'b1, 32'h0000_4000, 16'hFFFF, d, 0, 0);
    d[43:40] = 4'b1010; d[47] = 1'b0;
    run_op("R7",  32'h0000_0028, 2'd0, 1'b1, 32'h0000_4000, 16'hFFFF, d, 3, 0);
    d = good_desc(32'h1234_5678, 20'hF_FFFF); d[44] = 1'b1;
    run_op("R7",  32'h0000_0028, 2'd0, 1'b1, 32'h0000_4000, 16'hFFFF, d, 0, 0);
    d = good_desc(32'h1234_5678, 20'hF_FFFF); d[47] = 1'b0;
    run_op("R8",  32'h0000_0031, 2'd0, 1'b1, 32'h0000_4000, 16'hFFFF, d, 2, 0);
    d = good_desc(32'hDEAD_BEEF, 20'h0_0FFF);
    run_op("R10", 32'hFFFF_0040, 2'd0, 1'b1, 32'hFFFF_FF00, 16'hFFFF, d, 1, 0);
    run_op("R11", 32'h0000_0048, 2'd0, 1'b1, 32'h0000_8000, 16'hFFFF, d, 3, 1);
    run_op("R11", 32'h0000_0050, 2'd0, 1'b1, 32'h0000_8000, 16'hFFFF, d, 0, 1);

    for (int i = 0; i < 300; i++) begin
      logic [1:0] cp;
      logic       pm;
      int         r;
      d = {$urandom, $urandom};
      r = $urandom % 8;
      if (r < 6) begin d[43:40] = 4'b0010; d[44] = 1'b0; d[47] = (r != 5); end
      if ($urandom % 2 == 0)
        s = {$urandom} & 32'hFFFF_01FB | (($urandom % 8 == 0) ? 32'h4 : 32'h0);
      else
        s = $urandom;
      gl = ($urandom % 2 == 0) ? 16'(($urandom % 512) | 7) : 16'($urandom);
      pm = ($urandom % 16) != 0;
      cp = ($urandom % 8 == 0) ? 2'($urandom) : 2'd0;
      run_op("R9", s, cp, pm, $urandom, gl, d, int'($urandom % 4), ($urandom % 8) == 0);
    end

    summary();
    $finish;
  end
endmodule